// File: doc/BRIEF.md
# Periodic Pulse Remover

This block sits in a stream of single-cycle pulse strobes and deletes exactly one of those pulses whenever an internally scheduled removal command comes due. The schedule comes from a reference tick strobe divided by a programmable count D. A command therefore falls due once every D reference ticks. Over a long window the output rate equals the input rate minus the reference rate divided by D. Because D is an integer, the mean output rate can be trimmed in steps that are a fraction of the reference rate rather than whole multiples of it.

A command that falls due is held pending until the next input pulse arrives, and that pulse is the one suppressed. If a second command falls due while the first is still waiting, the second is dropped and a sticky overrun flag is raised. A division count of zero turns removal off entirely. Two running tallies, of pulses passed and pulses removed, let a surrounding check confirm the bookkeeping.

Top module: `pulse_thinner`

## Requirements
- R1: Each removal command that is accepted suppresses exactly one input pulse, and `removed_count` rises by one in the clock edge that follows the suppressed pulse. At most one of the two tallies changes per cycle.
- R2: With `div_count` = D > 0, a removal command falls due on every D-th `ref_tick`, counted from reset or from the previous command. If D is lowered below the ticks already counted, the command falls due on the next tick.
- R3: A command that falls due stays pending until the next `pulse_in`, and that pulse is suppressed. A `pulse_in` in the very cycle the command falls due is itself suppressed.
- R4: When a command falls due while another is still pending, `overrun` goes to 1 and the extra command is dropped. `overrun` then stays at 1 until reset.
- R5: While `div_count` is 0, no command falls due, any pending command is cleared, and every input pulse passes.
- R6: `pulse_out` is registered. It is 1 exactly one cycle after an input pulse that is not suppressed, and it is never 1 without an input pulse in the previous cycle.
- R7: `passed_count` rises by one for every pulse that reaches `pulse_out`. Both tallies wrap modulo 2^TALLY_W in wrap mode, so their sum tracks the number of input pulses modulo 2^TALLY_W.
- R8: During and right after reset, `pulse_out` and `overrun` are 0 and both tallies are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pulse_in | input | 1 | Input pulse strobe, one cycle per pulse |
| ref_tick | input | 1 | Reference tick strobe |
| div_count | input | CNT_W | Reference ticks per removal command; 0 disables removal |
| pulse_out | output | 1 | Thinned pulse strobe, one cycle after the input pulse |
| overrun | output | 1 | Sticky flag: a command was dropped because one was already pending |
| passed_count | output | TALLY_W | Running count of pulses passed |
| removed_count | output | TALLY_W | Running count of pulses removed |

## Verification
The checker tests these rules on every cycle:
- An output pulse always has an input pulse in the cycle before it.
- `overrun` never clears once it is set.
- The two tallies never move in the same cycle.
- `passed_count` steps exactly when `pulse_out` fires.
- A zero division count freezes the removed tally.

Some behaviour only the bench scenarios can show: the D-tick spacing of commands, pending across idle gaps, suppression of the same-cycle pulse, and the dropping of the extra command on overrun. The bench shows these by comparing against a cycle model driven by random and directed traffic.

// File: rtl/pulse_thinner_pkg.sv
package pulse_thinner_pkg;

   // Behaviour of a tally at its top value
   typedef enum logic {
      TALLY_WRAP     = 1'b0,
      TALLY_SATURATE = 1'b1
   } tally_mode_e;

   localparam int unsigned DEF_CNT_W   = 8;
   localparam int unsigned DEF_TALLY_W = 16;
   localparam int unsigned N_TALLIES   = 2;
   localparam int unsigned TALLY_PASS  = 0;
   localparam int unsigned TALLY_DROP  = 1;

endpackage

// File: rtl/pt_ref_divider.sv
module pt_ref_divider #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_tick,
   input  logic [CNT_W-1:0] div_count,
   output logic             enable,
   output logic             remove_req
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] tick_cnt;
   logic             at_limit;

   assign enable     = (div_count != '0);
   // >= so that lowering the count below the ticks already seen fires on the next tick
   assign at_limit   = (tick_cnt >= (div_count - ONE));
   assign remove_req = enable && ref_tick && at_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_cnt <= '0;
      end else if (!enable) begin
         tick_cnt <= '0;
      end else if (ref_tick) begin
         tick_cnt <= at_limit ? '0 : tick_cnt + ONE;
      end
   end

endmodule

// File: rtl/pt_scheduler.sv
module pt_scheduler (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic remove_req,
   input  logic pulse_in,
   output logic remove_now,
   output logic overrun
);

   logic pending;
   logic armed;

   assign armed      = pending || remove_req;
   assign remove_now = enable && pulse_in && armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
      end else if (!enable) begin
         pending <= 1'b0;
      end else if (remove_now) begin
         pending <= 1'b0;          // any second request this cycle is dropped
      end else begin
         pending <= armed;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         overrun <= 1'b0;
      end else if (remove_req && pending) begin
         overrun <= 1'b1;
      end
   end

endmodule

// File: rtl/pt_tally.sv
module pt_tally
   import pulse_thinner_pkg::*;
#(
   parameter int unsigned W    = 16,
   parameter tally_mode_e MODE = TALLY_WRAP
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);

   localparam logic [W-1:0] STEP = W'(1);
   localparam logic [W-1:0] TOP  = {W{1'b1}};

   logic bump;

   generate
      if (MODE == TALLY_SATURATE) begin : g_sat
         assign bump = inc && (count != TOP);
      end else begin : g_wrap
         assign bump = inc;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (bump) begin
         count <= count + STEP;
      end
   end

endmodule

// File: rtl/pulse_thinner.sv
module pulse_thinner
   import pulse_thinner_pkg::*;
#(
   parameter int unsigned CNT_W      = DEF_CNT_W,
   parameter int unsigned TALLY_W    = DEF_TALLY_W,
   parameter tally_mode_e TALLY_MODE = TALLY_WRAP
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pulse_in,
   input  logic               ref_tick,
   input  logic [CNT_W-1:0]   div_count,
   output logic               pulse_out,
   output logic               overrun,
   output logic [TALLY_W-1:0] passed_count,
   output logic [TALLY_W-1:0] removed_count
);

   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
         $error("pulse_thinner: CNT_W must lie in 1..32");
      end
      if (TALLY_W < 2 || TALLY_W > 64) begin : g_bad_tally_w
         $error("pulse_thinner: TALLY_W must lie in 2..64");
      end
   endgenerate

   logic enable;
   logic remove_req;
   logic remove_now;
   logic pass_now;
   logic [N_TALLIES-1:0] tally_inc;
   logic [TALLY_W-1:0]   tally_val [N_TALLIES];

   pt_ref_divider #(
      .CNT_W (CNT_W)
   ) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_tick   (ref_tick),
      .div_count  (div_count),
      .enable     (enable),
      .remove_req (remove_req)
   );

   pt_scheduler u_sched (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .remove_req (remove_req),
      .pulse_in   (pulse_in),
      .remove_now (remove_now),
      .overrun    (overrun)
   );

   assign pass_now = pulse_in && !remove_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_out <= 1'b0;
      end else begin
         pulse_out <= pass_now;
      end
   end

   assign tally_inc[TALLY_PASS] = pass_now;
   assign tally_inc[TALLY_DROP] = remove_now;

   generate
      for (genvar gi = 0; gi < N_TALLIES; gi++) begin : g_tally
         pt_tally #(
            .W    (TALLY_W),
            .MODE (TALLY_MODE)
         ) u_tally (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (tally_inc[gi]),
            .count (tally_val[gi])
         );
      end
   endgenerate

   assign passed_count  = tally_val[TALLY_PASS];
   assign removed_count = tally_val[TALLY_DROP];

endmodule

// File: rtl/pulse_thinner_chk.sv
module pulse_thinner_chk
   import pulse_thinner_pkg::*;
#(
   parameter int unsigned CNT_W      = DEF_CNT_W,
   parameter int unsigned TALLY_W    = DEF_TALLY_W,
   parameter tally_mode_e TALLY_MODE = TALLY_WRAP
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pulse_in,
   input logic [CNT_W-1:0]   div_count,
   input logic               pulse_out,
   input logic               overrun,
   input logic [TALLY_W-1:0] passed_count,
   input logic [TALLY_W-1:0] removed_count
);

   localparam logic [TALLY_W-1:0] STEP = TALLY_W'(1);

   AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_out |-> $past(pulse_in)); // R6

   AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun); // R4

   AST_ZERO_DIV_NO_REMOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (div_count == '0) |=> $stable(removed_count)); // R5

   AST_ONE_TALLY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({passed_count != $past(passed_count),
                  removed_count != $past(removed_count)}) <= 1); // R1

   generate
      if (TALLY_MODE == TALLY_WRAP) begin : g_wrap_chk
         AST_PASS_TRACKS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_out == (passed_count == $past(passed_count) + STEP)); // R7
      end
   endgenerate

endmodule

bind pulse_thinner pulse_thinner_chk #(
   .CNT_W      (CNT_W),
   .TALLY_W    (TALLY_W),
   .TALLY_MODE (TALLY_MODE)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .pulse_in      (pulse_in),
   .div_count     (div_count),
   .pulse_out     (pulse_out),
   .overrun       (overrun),
   .passed_count  (passed_count),
   .removed_count (removed_count)
);

// File: tb/pulse_thinner_bench.sv
module pulse_thinner_bench;

   localparam int CLK_PERIOD = 10;
   localparam int CW = 8;
   localparam int TW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pulse_in = 1'b0;
   logic          ref_tick = 1'b0;
   logic [CW-1:0] div_count = '0;
   logic          pulse_out;
   logic          overrun;
   logic [TW-1:0] passed_count;
   logic [TW-1:0] removed_count;

   int n_cmp = 0;
   int n_bad = 0;
   int n_in  = 0;

   // reference model state
   logic [CW-1:0] m_rc;
   logic          m_pend, m_ov, m_out;
   logic [TW-1:0] m_pass, m_rem;

   always #(CLK_PERIOD/2) clk = ~clk;

   pulse_thinner #(.CNT_W(CW), .TALLY_W(TW)) u_pulse_thinner (
      .clk           (clk),
      .rst_n         (rst_n),
      .pulse_in      (pulse_in),
      .ref_tick      (ref_tick),
      .div_count     (div_count),
      .pulse_out     (pulse_out),
      .overrun       (overrun),
      .passed_count  (passed_count),
      .removed_count (removed_count)
   );

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic due(input logic tick, input logic [CW-1:0] d, input logic [CW-1:0] rc);
      return (d != 0) && tick && (rc >= d - 1);
   endfunction

   task automatic model_reset();
      m_rc = '0; m_pend = 0; m_ov = 0; m_out = 0; m_pass = '0; m_rem = '0;
   endtask

   // one clock: drive at negedge, advance model, compare after posedge
   task automatic step(input logic pin, input logic tick, input logic [CW-1:0] d);
      logic en, rq, rm;
      @(negedge clk);
      pulse_in = pin; ref_tick = tick; div_count = d;
      if (pin) n_in++;
      en = (d != 0);
      rq = due(tick, d, m_rc);
      rm = en && pin && (m_pend || rq);
      if (rq && m_pend) m_ov = 1;
      m_rc   = !en ? '0 : (tick ? (rq ? '0 : m_rc + 1) : m_rc);
      m_pend = !en ? 1'b0 : (rm ? 1'b0 : (m_pend || rq));
      m_out  = pin && !rm;
      m_pass = m_pass + TW'(m_out);
      m_rem  = m_rem + TW'(rm);
      @(posedge clk); #1;
      check(pulse_out == m_out, "R6 pulse_out", pulse_out, m_out);
      check(removed_count == m_rem, "R1 removed_count", removed_count, m_rem);
      check(passed_count == m_pass, "R7 passed_count", passed_count, m_pass);
      check(overrun == m_ov, "R4 overrun", overrun, m_ov);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [TW-1:0] r0;
      logic [CW-1:0] dv;
      int seed;
      seed = 32'h5EED_1234;
      void'($urandom(seed));
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      // R8: reset state
      check(pulse_out == 0 && overrun == 0, "R8 flags in reset", {pulse_out, overrun}, 0);
      check(passed_count == 0 && removed_count == 0, "R8 tallies in reset",
            passed_count + removed_count, 0);
      @(negedge clk); rst_n = 1;

      // R5: zero count, ticks and pulses everywhere, nothing removed
      for (int i = 0; i < 40; i++) step(1, 1, 0);
      check(removed_count == 0, "R5 no removal at zero count", removed_count, 0);
      check(passed_count == 40, "R5 all pulses pass", passed_count, 40);

      // R2: D=3, pulses every cycle; every third tick removes one
      r0 = removed_count;
      for (int i = 0; i < 9; i++) step(1, 1, 3);
      check(removed_count == r0 + 3, "R2 one removal per three ticks", removed_count, r0 + 3);

      // R3: request falls due with no pulse, held across idle cycles
      for (int i = 0; i < 3; i++) step(0, 1, 3);   // third tick arms
      r0 = removed_count;
      for (int i = 0; i < 6; i++) step(0, 0, 3);
      check(removed_count == r0, "R3 held without pulse", removed_count, r0);
      step(1, 0, 3);
      check(removed_count == r0 + 1 && pulse_out == 0, "R3 next pulse suppressed",
            removed_count, r0 + 1);
      step(1, 0, 3);
      check(pulse_out == 1, "R3 following pulse passes", pulse_out, 1);

      // R5: pending cleared by a zero count
      for (int i = 0; i < 3; i++) step(0, 1, 3);
      step(0, 0, 0);
      r0 = removed_count;
      step(1, 0, 3);
      check(removed_count == r0 && pulse_out == 1, "R5 pending cleared", removed_count, r0);

      // R4: D=1, ticks with no pulses -> second request overruns
      check(overrun == 0, "R4 overrun clear before", overrun, 0);
      step(0, 1, 1);
      step(0, 1, 1);
      check(overrun == 1, "R4 overrun raised", overrun, 1);
      r0 = removed_count;
      step(1, 0, 1);
      step(1, 0, 1);
      check(removed_count == r0 + 1, "R4 extra request dropped", removed_count, r0 + 1);

      // random traffic, count changed in bursts
      for (int b = 0; b < 20; b++) begin
         dv = CW'($urandom_range(0, 6));
         for (int i = 0; i < 150; i++)
            step(($urandom_range(0, 9) < 6), ($urandom_range(0, 9) < 3), dv);
      end
      // R7: tallies account for every input pulse (modulo width)
      check(TW'(passed_count + removed_count) == TW'(n_in), "R7 tally sum",
            TW'(passed_count + removed_count), TW'(n_in));

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule